// File: doc/BRIEF.md
# Boot-Preloaded Write-Back Cache

This block is a small, fully associative write-back cache placed between a 32-bit CPU port and a burst port toward DRAM. The system it serves has no boot ROM. For that reason the cache leaves reset already holding a boot image, with every line marked valid and dirty. The processor fetches its first instructions from the cache. The first eviction of a line, or the first flush, copies that preloaded code into DRAM. After that the cache behaves as an ordinary write-back cache.

The cache has eight lines of 256 bytes each, which is 64 words of 32 bits per line. On a miss it picks the victim in round-robin order. A dirty victim is written back before the new line is read in, and each transfer is a 64-beat burst in ascending address order. A flush input walks all lines, writes back the dirty ones, cleans them, and reports completion.

Top module: `wb_boot_cache`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cpu_ack`, `flush_done`, `mem_rd` and `mem_wr` are all 0.
- R2: After reset, line i holds the 256-byte block at byte address BOOT_BASE + 256*i. Word k of the boot image (k = 64*i + word) equals BOOT_SEED XOR (k * 32'h9E3779B1), truncated to 32 bits. Reads of those addresses hit and start no DRAM burst.
- R3: A hit is answered with `cpu_ack` high for exactly one cycle, and only after a request. On a read, `cpu_rdata` holds the word while `cpu_ack` is high. The requester drops `cpu_req` once it sees `cpu_ack`. Addresses are word aligned (bits 1:0 are zero).
- R4: A write hit changes only the bytes whose enable is set, where `cpu_be[b]` covers bits 8b+7 down to 8b. It also marks the line dirty.
- R5: Victims are chosen round robin, starting at line 0 after reset and moving forward by one after each line fill. A line that has not been evicted keeps hitting.
- R6: A miss on a dirty victim writes the victim back before the fill starts. The write-back holds `mem_wr` high with `mem_addr` at the line base, and sends one beat per cycle in which `mem_wready` is high, 64 beats at ascending word addresses. The fill then holds `mem_rd` high and takes one beat per cycle in which `mem_rvalid` is high.
- R7: A miss on a clean victim performs only the fill burst, with no write burst.
- R8: A one-cycle pulse on `flush` while the cache is idle starts a walk over all eight lines. The walk writes back every dirty line and then pulses `flush_done` for one cycle. The first flush after reset therefore copies the whole boot image into DRAM.
- R9: A flush leaves every line clean, so a second flush with no writes in between issues no write burst.
- R10: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| flush | input | 1 | Flush start pulse |
| flush_done | output | 1 | One-cycle pulse when the flush walk ends |
| mem_addr | output | AW | Line base address of the current burst |
| mem_rd | output | 1 | Fill burst in progress |
| mem_wr | output | 1 | Write-back burst in progress |
| mem_wdata | output | 32 | Write-back beat data |
| mem_rdata | input | 32 | Fill beat data |
| mem_rvalid | input | 1 | Fill beat strobe |
| mem_wready | input | 1 | Write-back beat strobe |

## Verification
The CPU port is tested with reads spread across the whole boot image, with partial and full byte-enable writes, and with misses that land on a dirty victim and on a clean victim. Counting read and write bursts separately shows apart a hit, a clean replacement and a dirty replacement. The DRAM model withholds its beat strobes on some cycles, so a beat taken without a strobe shows up as misplaced data in DRAM. Comparing DRAM contents after the first flush shows whether each boot word landed at its own address. A second flush and a chain of misses then show whether dirty bits were cleared and whether the victim pointer advances in order.

// File: rtl/wb_boot_cache.sv
module wb_boot_cache #(
  parameter int             NLINES     = 8,
  parameter int             LINE_BYTES = 256,
  parameter int             AW         = 32,
  parameter logic [AW-1:0]  BOOT_BASE  = 32'h000F_F800,
  parameter logic [31:0]    BOOT_SEED  = 32'hC0DE_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  input  logic [3:0]    cpu_be,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_ack,
  input  logic          flush,
  output logic          flush_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rvalid,
  input  logic          mem_wready
);
  localparam int WPL  = LINE_BYTES / 4;
  localparam int WBW  = $clog2(WPL);
  localparam int OFF  = $clog2(LINE_BYTES);
  localparam int LB   = $clog2(NLINES);
  localparam int TW   = AW - OFF;
  localparam int NW   = NLINES * WPL;

  typedef enum logic [2:0] {S_IDLE, S_RESP, S_WB, S_FILL, S_FSCAN, S_FDONE} st_t;

  function automatic logic [31:0] boot_word(int k);
    return BOOT_SEED ^ (32'(k) * 32'h9E37_79B1);
  endfunction

  st_t               st;
  logic [31:0]       data [NW];
  logic [TW-1:0]     tag  [NLINES];
  logic [NLINES-1:0] valid, dirty;
  logic [LB-1:0]     line, rr, fidx, hl;
  logic [WBW-1:0]    beat;
  logic [TW-1:0]     ftag;
  logic              in_flush, hit;

  always_comb begin
    hit = 1'b0;
    hl  = '0;
    for (int i = 0; i < NLINES; i++)
      if (valid[i] && tag[i] == cpu_addr[AW-1:OFF]) begin
        hit = 1'b1;
        hl  = LB'(i);
      end
  end

  wire [LB+WBW-1:0] cidx  = {hl, cpu_addr[OFF-1:2]};
  wire [LB+WBW-1:0] bidx  = {line, beat};
  wire              blast = (beat == WBW'(WPL - 1));
  wire              flast = (fidx == LB'(NLINES - 1));

  assign cpu_ack    = (st == S_RESP);
  assign flush_done = (st == S_FDONE);
  assign mem_wr     = (st == S_WB);
  assign mem_rd     = (st == S_FILL);
  assign mem_wdata  = data[bidx];
  assign mem_addr   = {(st == S_WB) ? tag[line] : ftag, OFF'(0)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      valid     <= '1;
      dirty     <= '1;
      rr        <= '0;
      line      <= '0;
      fidx      <= '0;
      beat      <= '0;
      ftag      <= '0;
      in_flush  <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < NLINES; i++) tag[i] <= BOOT_BASE[AW-1:OFF] + TW'(i);
      for (int k = 0; k < NW; k++) data[k] <= boot_word(k);
    end else begin
      case (st)
        S_IDLE:
          if (flush) begin
            in_flush <= 1'b1;
            fidx     <= '0;
            st       <= S_FSCAN;
          end else if (cpu_req) begin
            if (hit) begin
              if (cpu_we) begin
                for (int b = 0; b < 4; b++)
                  if (cpu_be[b]) data[cidx][8*b +: 8] <= cpu_wdata[8*b +: 8];
                dirty[hl] <= 1'b1;
              end else begin
                cpu_rdata <= data[cidx];
              end
              st <= S_RESP;
            end else begin
              in_flush <= 1'b0;
              line     <= rr;
              ftag     <= cpu_addr[AW-1:OFF];
              beat     <= '0;
              st       <= (valid[rr] && dirty[rr]) ? S_WB : S_FILL;
            end
          end
        S_RESP: st <= S_IDLE;
        S_WB:
          if (mem_wready) begin
            beat <= beat + 1'b1;
            if (blast) begin
              dirty[line] <= 1'b0;
              if (!in_flush)  st <= S_FILL;
              else if (flast) st <= S_FDONE;
              else begin
                fidx <= fidx + 1'b1;
                st   <= S_FSCAN;
              end
            end
          end
        S_FILL:
          if (mem_rvalid) begin
            data[bidx] <= mem_rdata;
            beat       <= beat + 1'b1;
            if (blast) begin
              tag[line]   <= ftag;
              valid[line] <= 1'b1;
              dirty[line] <= 1'b0;
              rr          <= rr + 1'b1;
              st          <= S_IDLE;
            end
          end
        S_FSCAN:
          if (dirty[fidx]) begin
            line <= fidx;
            beat <= '0;
            st   <= S_WB;
          end else if (flast) st <= S_FDONE;
          else fidx <= fidx + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R3
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_ack |-> $past(cpu_req));
  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_ack |=> !cpu_ack);
  // R3
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_req |-> cpu_addr[1:0] == 2'b00);
  // R6
  wb_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && $past(mem_wr)) |-> $stable(mem_addr));
  // R6
  fill_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_done |=> !flush_done);
endmodule

// File: tb/wb_boot_cache_tb.sv
module wb_boot_cache_tb;
  localparam logic [31:0] BB   = 32'h000F_F800;
  localparam logic [31:0] SEED = 32'hC0DE_0000;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, flush = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata, mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0]  cpu_be = 0;
  logic cpu_ack, flush_done, mem_rd, mem_wr, mem_rvalid = 0, mem_wready = 0;

  wb_boot_cache u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, wbeat = 0, rbeat = 0, wr_bursts = 0, rd_bursts = 0;
  bit pw = 0, pr = 0;
  logic [31:0] dram [int];
  logic [31:0] refm [int];
  logic [31:0] exp_q [$];
  string       req_q [$];

  function automatic logic [31:0] bootw(int k);
    return SEED ^ (32'(k) * 32'h9E37_79B1);
  endfunction
  function automatic logic [31:0] dget(int a);
    return dram.exists(a) ? dram[a] : (32'(a) ^ 32'h5A5A_0000);
  endfunction
  function automatic logic [31:0] rget(int a);
    return refm.exists(a) ? refm[a] : (32'(a) ^ 32'h5A5A_0000);
  endfunction

  task automatic check(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // DRAM model: strobes decided and beats recorded at the negedge before the edge that uses them
  always @(negedge clk) begin
    cyc++;
    if (mem_wr && !pw) wr_bursts++;
    if (mem_rd && !pr) rd_bursts++;
    pw = mem_wr; pr = mem_rd;
    if (mem_wr && (cyc % 3 != 0)) begin
      mem_wready = 1;
      dram[int'(mem_addr >> 2) + wbeat] = mem_wdata;
      wbeat++;
    end else begin
      mem_wready = 0;
      if (!mem_wr) wbeat = 0;
    end
    if (mem_rd && (cyc % 4 != 1)) begin
      mem_rvalid = 1;
      mem_rdata  = dget(int'(mem_addr >> 2) + rbeat);
      rbeat++;
    end else begin
      mem_rvalid = 0;
      if (!mem_rd) rbeat = 0;
    end
  end

  // monitor: pops expected read data on each read ack
  always @(negedge clk) begin
    if (rst_n && cpu_ack && !cpu_we) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected ack", cpu_rdata, 0);
      else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(cpu_rdata == e, r, cpu_rdata, e);
      end
    end
  end

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wd, logic [3:0] be, string r);
    int a = int'(addr >> 2);
    @(negedge clk);
    cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be; cpu_req = 1;
    if (!we) begin
      exp_q.push_back(rget(a));
      req_q.push_back(r);
    end else begin
      logic [31:0] v = rget(a);
      for (int b = 0; b < 4; b++) if (be[b]) v[8*b +: 8] = wd[8*b +: 8];
      refm[a] = v;
    end
    do @(negedge clk); while (!cpu_ack);
    cpu_req = 0;
  endtask

  task automatic do_flush(string r);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    while (!flush_done) @(negedge clk);
    check(flush_done, r, flush_done, 1);
    @(negedge clk);
    check(!flush_done, {r, " done pulse width"}, flush_done, 0);
  endtask

  task automatic cmp_region(int base, int n, string r);
    int bad = 0;
    for (int i = 0; i < n; i++) if (dget(base + i) !== rget(base + i)) bad++;
    check(bad == 0, r, bad, 0);
  endtask

  initial begin
    int w0, r0;
    for (int k = 0; k < 512; k++) refm[int'(BB >> 2) + k] = bootw(k);
    repeat (4) @(negedge clk);
    check(!cpu_ack && !flush_done && !mem_rd && !mem_wr, "R1 outputs in reset",
          {cpu_ack, flush_done, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!cpu_ack && !flush_done && !mem_rd && !mem_wr, "R1 outputs after reset",
          {cpu_ack, flush_done, mem_rd, mem_wr}, 0);

    access(0, BB + 0*4,   0, 0, "R2 boot word 0");
    access(0, BB + 70*4,  0, 0, "R2 boot word 70");
    access(0, BB + 511*4, 0, 0, "R2 boot word 511");
    access(0, BB + 200*4, 0, 0, "R3 boot word 200");
    check(wr_bursts == 0 && rd_bursts == 0, "R2 no DRAM traffic on boot hits", wr_bursts + rd_bursts, 0);

    access(1, BB + 130*4, 32'hAABB_CCDD, 4'b0101, "R4 partial write");
    access(0, BB + 130*4, 0, 0, "R4 merged bytes");
    access(1, BB + 131*4, 32'h1234_5678, 4'b1111, "R4 full write");
    access(0, BB + 131*4, 0, 0, "R4 full word");
    access(1, BB + 132*4, 32'hFFFF_FFFF, 4'b0000, "R4 no enables");
    access(0, BB + 132*4, 0, 0, "R4 untouched word");

    w0 = wr_bursts; r0 = rd_bursts;
    access(0, 32'h0010_0000, 0, 0, "R6 miss data");
    check(wr_bursts - w0 == 1, "R6 write-back count", wr_bursts - w0, 1);
    check(rd_bursts - r0 == 1, "R6 fill count", rd_bursts - r0, 1);
    cmp_region(int'(BB >> 2), 64, "R6 evicted boot line in DRAM");

    r0 = rd_bursts;
    access(0, 32'h0010_0004, 0, 0, "R5 hit in filled line");
    access(1, 32'h0010_0008, 32'hCAFE_F00D, 4'b1111, "R4 write filled line");
    check(rd_bursts == r0, "R5 filled line hits", rd_bursts - r0, 0);

    w0 = wr_bursts;
    do_flush("R8 flush done");
    check(wr_bursts - w0 == 8, "R8 dirty lines written", wr_bursts - w0, 8);
    cmp_region(int'(BB >> 2), 512, "R8 boot image in DRAM");
    cmp_region(int'(32'h0010_0000 >> 2), 64, "R8 dirty fetched line in DRAM");

    w0 = wr_bursts;
    do_flush("R9 second flush done");
    check(wr_bursts == w0, "R9 clean after flush", wr_bursts - w0, 0);

    w0 = wr_bursts; r0 = rd_bursts;
    access(0, 32'h0020_0000, 0, 0, "R7 clean miss data");
    check(wr_bursts == w0, "R7 no write-back", wr_bursts - w0, 0);
    check(rd_bursts - r0 == 1, "R7 one fill", rd_bursts - r0, 1);

    r0 = rd_bursts;
    access(0, BB + 128*4, 0, 0, "R5 line 2 still cached");
    check(rd_bursts == r0, "R5 line 2 hit", rd_bursts - r0, 0);
    access(0, BB + 64*4, 0, 0, "R5 refetched line 1 data");
    check(rd_bursts - r0 == 1, "R5 line 1 was victim", rd_bursts - r0, 1);
    access(0, BB + 129*4, 0, 0, "R5 line 2 refetched data");
    check(rd_bursts - r0 == 2, "R5 line 2 was next victim", rd_bursts - r0, 2);
    access(0, BB + 450*4, 0, 0, "R5 line 7 still cached");
    check(rd_bursts - r0 == 2, "R5 line 7 hit", rd_bursts - r0, 2);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads acknowledged", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired actual=%h expected=%h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule